// File: doc/BRIEF.md
# SRTS Residual Difference Generator

This block supports clock recovery for a line that carries unstructured constant-bit-rate data. A 4-bit counter runs on the network reference clock. Once per fixed span of line-clock cycles, the line-clock domain samples that counter to form a local residual time stamp. The sample crosses into the system clock domain. There the block asks an external queue for the matching remote time stamp over a request/acknowledge handshake. It then subtracts the remote stamp from the local one.

The 4-bit result is read as a two's-complement correction. It leaves on two paths. The first is a one-cycle strobed output toward the frequency synthesizer. The second is an external output that holds the most recent value. Processing takes place only when all of these hold: the software enable is set, the active-low hardware disable pin is high, the line is enabled, and the line is set up for unstructured data. The reference clock should be faster than the line clock but slower than twice the line clock; 2.43 MHz is the usual choice for the slower primary-rate lines.

Top module: `srts_rdiff_gen`

## Requirements
- R1: The function is active only while `sw_en`, `hw_dis_n`, `line_en` and `line_udf` are all 1. While it is inactive, no request is raised and a new local stamp is discarded. If the function becomes inactive while `q_req` is high, `q_req` drops on the next system edge and no difference or timeout is produced.
- R2: The reference counter is 4 bits wide. It counts rising edges of `ref_clk` modulo 16 and is cleared to 0 while `ref_rst_n` is low.
- R3: The local stamp is latched on the PERIOD-th rising edge of `line_clk` after line reset, and every PERIOD edges after that (3008 by default). Its value is the reference count as it stood at the `line_clk` edge two edges before the latching edge, because the count passes through a two-stage synchronizer.
- R4: A new local stamp that reaches the system domain while the function is active and idle raises `q_req` within 8 system cycles. `q_req` stays high until the stamp is accepted, the wait times out, or the function is gated off.
- R5: The remote stamp on `q_rts` is taken on the system edge where `q_req` and `q_ack` are both 1. A `q_ack` pulse while `q_req` is low has no effect.
- R6: On the system cycle after acceptance, `syn_vld` is 1 for exactly one cycle. During that cycle `syn_diff` equals (local − remote) modulo 16, read as a signed value from −8 to +7.
- R7: `ext_diff` takes the new difference in the same cycle as `syn_vld` and holds it until the next difference. It is 0 after reset.
- R8: Suppose `q_req` has been high for 16 system edges with no `q_ack`. Then `q_req` drops and `q_timeout` is 1 for one cycle, with no difference produced. An acknowledge seen on the 16th edge is still accepted.
- R9: While `rst_n` is low, `q_req`, `syn_vld`, `q_timeout` and `ext_diff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Network reference clock |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| line_clk | input | 1 | Line transmit clock |
| line_rst_n | input | 1 | Synchronous active-low reset, line domain |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, system domain |
| sw_en | input | 1 | Software enable of the function |
| hw_dis_n | input | 1 | Hardware disable, active low |
| line_en | input | 1 | Per-line enable |
| line_udf | input | 1 | Line carries unstructured data |
| q_req | output | 1 | Read request to the remote stamp queue |
| q_ack | input | 1 | Queue acknowledge; `q_rts` valid |
| q_rts | input | 4 | Remote residual time stamp |
| syn_diff | output | 4 | Signed difference toward the synthesizer |
| syn_vld | output | 1 | One-cycle strobe for `syn_diff` |
| ext_diff | output | 4 | Held copy of the last difference |
| q_timeout | output | 1 | One-cycle pulse when the queue fails to answer |

## Verification
Most internal faults show up in the value of `syn_diff`, one system cycle after the accepting acknowledge. A miscount in the reference counter, a wrong synchronizer depth or a wrong period length each shift the expected local stamp. Faults in the handshake state show at the ports straight away. Examples are a request that starts without a fresh stamp, a request that ends too early or too late against the 16-cycle window, and a strobe that lasts longer than one cycle. The bench predicts every system cycle from a behavioural count of clock edges, so a control fault is seen in the cycle it occurs. A value fault is seen at the first acceptance after it occurs.

// File: rtl/srts_pkg.sv
// Shared definitions for the residual difference generator.
package srts_pkg;
    // Sequencer states of the system-domain request controller.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } req_state_t;
endpackage

// File: rtl/srts_ref_cnt.sv
// Free-running reference counter.
// Counts ref_clk edges and publishes the count as registered Gray code,
// so that another clock domain can sample it one bit change at a time.
// Assumes: W >= 2.
module srts_ref_cnt #(
    parameter int W = 4
) (
    input  logic         ref_clk,
    input  logic         ref_rst_n,
    output logic [W-1:0] gray_o
);
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nx;

    assign bin_nx = bin_q + 1'b1;

    // Advance the binary count and register its Gray image.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end

    AST_GRAY_STEP: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $countones(gray_o ^ $past(gray_o)) <= 1); // R2
endmodule

// File: rtl/srts_stamp_smp.sv
// Local stamp sampler (line clock domain).
// Synchronizes the Gray reference count, decodes it to binary and latches it
// once every PERIOD line cycles. Each latch flips a toggle that the system
// domain watches. The stamp is held stable between toggles.
// Assumes: PERIOD >= 2, SYNC >= 2.
module srts_stamp_smp #(
    parameter int W      = 4,
    parameter int PERIOD = 3008,
    parameter int SYNC   = 2
) (
    input  logic         line_clk,
    input  logic         line_rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] stamp_o,
    output logic         tog_o
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [W-1:0]  sync_q [SYNC];
    logic [CW-1:0] cnt_q;

    // Gray to binary conversion.
    function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Synchronizer chain for the reference count.
    always_ff @(posedge line_clk) begin
        if (!line_rst_n) begin
            for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= gray_i;
            for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    // Period counter; latch the stamp and flip the toggle at the end of each span.
    always_ff @(posedge line_clk) begin
        if (!line_rst_n) begin
            cnt_q   <= '0;
            stamp_o <= '0;
            tog_o   <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            stamp_o <= gray2bin(sync_q[SYNC-1]);
            tog_o   <= ~tog_o;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    AST_STAMP_HELD: assert property (@(posedge line_clk) disable iff (!line_rst_n)
        $stable(tog_o) |-> $stable(stamp_o)); // R3
endmodule

// File: rtl/srts_req_ctrl.sv
// Request controller (system clock domain).
// Detects a new local stamp through a synchronized toggle, requests the remote
// stamp, waits for the acknowledge or a timeout, and forms the modulo-2^W
// difference on the strobed output and the held external output.
// Assumes: the stamp from the line domain is stable long before its toggle
// arrives; TIMEOUT >= 2; SYNC >= 2.
module srts_req_ctrl
    import srts_pkg::*;
#(
    parameter int W       = 4,
    parameter int TIMEOUT = 16,
    parameter int SYNC    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         tog_i,
    input  logic [W-1:0] stamp_i,
    input  logic         ack_i,
    input  logic [W-1:0] rts_i,
    output logic         req_o,
    output logic [W-1:0] diff_o,
    output logic         vld_o,
    output logic [W-1:0] ext_o,
    output logic         tmo_o
);
    localparam int TW = $clog2(TIMEOUT);
    localparam logic [TW-1:0] WLAST = TW'(TIMEOUT - 1);

    logic [SYNC-1:0] tsync_q;
    logic            tprev_q;
    logic            evt;
    req_state_t      st_q;
    logic [TW-1:0]   wcnt_q;
    logic [W-1:0]    local_q;

    // Bring the toggle across and keep its previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsync_q <= '0;
            tprev_q <= 1'b0;
        end else begin
            tsync_q <= {tsync_q[SYNC-2:0], tog_i};
            tprev_q <= tsync_q[SYNC-1];
        end
    end

    assign evt   = tsync_q[SYNC-1] ^ tprev_q;
    assign req_o = (st_q == ST_WAIT);

    // Handshake sequencer, difference and timeout generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            wcnt_q  <= '0;
            local_q <= '0;
            diff_o  <= '0;
            vld_o   <= 1'b0;
            ext_o   <= '0;
            tmo_o   <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            tmo_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (evt && active_i) begin
                        st_q    <= ST_WAIT;
                        wcnt_q  <= '0;
                        local_q <= stamp_i;
                    end
                end
                ST_WAIT: begin
                    if (!active_i) begin
                        st_q <= ST_IDLE;
                    end else if (ack_i) begin
                        st_q   <= ST_IDLE;
                        diff_o <= local_q - rts_i;
                        ext_o  <= local_q - rts_i;
                        vld_o  <= 1'b1;
                    end else if (wcnt_q == WLAST) begin
                        st_q  <= ST_IDLE;
                        tmo_o <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !req_o); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && active_i && !ack_i && wcnt_q != WLAST) |=> req_o); // R4
    AST_VLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(ack_i && req_o)); // R5
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R6
    AST_EXT_ONLY_ON_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_o) |-> vld_o); // R7
    AST_TMO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmo_o && vld_o)); // R8
endmodule

// File: rtl/srts_rdiff_gen.sv
// Residual time stamp difference generator, one line.
// Ties together the reference counter, the line-domain sampler and the
// system-domain request controller, and forms the combined enable.
// Assumes: each domain has its own synchronous reset; ref_clk lies between
// one and two times the line clock frequency.
module srts_rdiff_gen #(
    parameter int RTS_W       = 4,
    parameter int PERIOD      = 3008,
    parameter int TIMEOUT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             line_clk,
    input  logic             line_rst_n,
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_en,
    input  logic             hw_dis_n,
    input  logic             line_en,
    input  logic             line_udf,
    output logic             q_req,
    input  logic             q_ack,
    input  logic [RTS_W-1:0] q_rts,
    output logic [RTS_W-1:0] syn_diff,
    output logic             syn_vld,
    output logic [RTS_W-1:0] ext_diff,
    output logic             q_timeout
);
    logic [RTS_W-1:0] gray_w;
    logic [RTS_W-1:0] stamp_w;
    logic             tog_w;
    logic             active;

    // Every gate must agree for the function to run.
    assign active = sw_en & hw_dis_n & line_en & line_udf;

    srts_ref_cnt #(.W(RTS_W)) u_ref (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .gray_o    (gray_w)
    );

    srts_stamp_smp #(.W(RTS_W), .PERIOD(PERIOD), .SYNC(SYNC_STAGES)) u_smp (
        .line_clk   (line_clk),
        .line_rst_n (line_rst_n),
        .gray_i     (gray_w),
        .stamp_o    (stamp_w),
        .tog_o      (tog_w)
    );

    srts_req_ctrl #(.W(RTS_W), .TIMEOUT(TIMEOUT), .SYNC(SYNC_STAGES)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .tog_i    (tog_w),
        .stamp_i  (stamp_w),
        .ack_i    (q_ack),
        .rts_i    (q_rts),
        .req_o    (q_req),
        .diff_o   (syn_diff),
        .vld_o    (syn_vld),
        .ext_o    (ext_diff),
        .tmo_o    (q_timeout)
    );
endmodule

// File: tb/srts_rdiff_gen_tb.sv
`timescale 1ns/1ps
module srts_rdiff_gen_tb;
    localparam real CLK_PERIOD  = 4.0;
    localparam real LINE_PERIOD = 10.0;
    localparam real REF_PERIOD  = 7.0;
    localparam int  PER         = 64;
    localparam int  STAMP_SYS   = 160;

    logic ref_clk = 0, line_clk = 0, clk = 0;
    logic ref_rst_n = 0, line_rst_n = 0, rst_n = 0;
    logic sw_en = 1, hw_dis_n = 1, line_en = 1, line_udf = 1;
    logic q_ack = 0;
    logic [3:0] q_rts = 0;
    logic q_req, syn_vld, q_timeout;
    logic [3:0] syn_diff, ext_diff;

    int checks = 0, errors = 0;

    srts_rdiff_gen #(.PERIOD(PER)) u_dut (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .line_clk(line_clk), .line_rst_n(line_rst_n),
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .hw_dis_n(hw_dis_n), .line_en(line_en),
        .line_udf(line_udf), .q_req(q_req), .q_ack(q_ack), .q_rts(q_rts),
        .syn_diff(syn_diff), .syn_vld(syn_vld), .ext_diff(ext_diff), .q_timeout(q_timeout)
    );

    always #(REF_PERIOD / 2.0)  ref_clk  = ~ref_clk;
    always #(LINE_PERIOD / 2.0) line_clk = ~line_clk;
    always #(CLK_PERIOD / 2.0)  clk      = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference count of ref_clk edges (R2).
    int refcnt = 0;
    always @(posedge ref_clk) begin
        if (!ref_rst_n) refcnt = 0;
        else refcnt = (refcnt + 1) % 16;
    end

    // Line-domain model: the stamp is the count seen two line edges earlier (R3).
    int ln = 0;
    int hist [4];
    int stamp_n = 0;
    bit pending = 0;
    int pend_val = 0;
    int pend_age = 0;
    always @(posedge line_clk) begin
        if (!line_rst_n) begin
            ln = 0;
        end else begin
            ln++;
            hist[ln % 4] = refcnt;
            if (ln % PER == 0) begin
                stamp_n++;
                if (sw_en && hw_dis_n && line_en && line_udf) begin
                    pending  = 1;
                    pend_val = hist[(ln - 2) % 4];
                    pend_age = 0;
                end
            end
        end
    end

    // System-domain model compared on every clock.
    bit m_wait = 0;
    int m_n = 0;
    int m_local = 0;
    int m_ext = 0;
    int ev = 0;
    int rises = 0;
    int vlds = 0;
    always @(posedge clk) begin
        bit a_rst, a_ack, a_act;
        int a_rts;
        bit e_req, e_vld, e_tmo;
        int e_diff;
        a_rst = rst_n; a_ack = q_ack; a_rts = q_rts;
        a_act = sw_en && hw_dis_n && line_en && line_udf;
        #1;
        if (!a_rst) begin
            m_wait = 0; m_ext = 0;
            check(q_req == 0 && syn_vld == 0 && q_timeout == 0 && ext_diff == 0,
                  "R9 outputs in reset", {q_req, syn_vld, q_timeout}, 0);
        end else begin
            e_req = 0; e_vld = 0; e_tmo = 0; e_diff = 0;
            if (m_wait) begin
                if (!a_act) begin
                    m_wait = 0; ev++;
                end else if (a_ack) begin
                    e_vld = 1; e_diff = (m_local - a_rts) & 15; m_ext = e_diff;
                    m_wait = 0; ev++;
                end else if (m_n == 15) begin
                    e_tmo = 1; m_wait = 0; ev++;
                end else begin
                    m_n++; e_req = 1;
                end
            end else if (q_req) begin
                if (pending && a_act) begin
                    m_wait = 1; m_n = 0; m_local = pend_val; pending = 0; e_req = 1; rises++;
                end else begin
                    check(0, "R4/R1 request without fresh stamp", 1, 0);
                    e_req = 1;
                end
            end
            if (pending) begin
                pend_age++;
                if (pend_age > 8) begin
                    check(0, "R4 request late", 0, 1);
                    pending = 0;
                end
            end
            if (syn_vld) vlds++;
            check(q_req == e_req, "R4 R8 R1 q_req", q_req, e_req);
            check(syn_vld == e_vld, "R6 R5 syn_vld", syn_vld, e_vld);
            if (e_vld) check(syn_diff == e_diff, "R6 R3 R2 syn_diff", syn_diff, e_diff);
            check(q_timeout == e_tmo, "R8 q_timeout", q_timeout, e_tmo);
            check(ext_diff == m_ext, "R7 ext_diff", ext_diff, m_ext);
        end
    end

    // Queue responder: acknowledge after ack_delay cycles of request (-1: never).
    int ack_delay = 0;
    int remote = 0;
    int rcnt = 0;
    bit stray = 0;
    always @(negedge clk) begin
        q_ack = 0;
        if (q_req) begin
            rcnt++;
            if (ack_delay >= 0 && rcnt == ack_delay + 1) begin
                q_ack = 1; q_rts = 4'(remote);
            end
        end else begin
            rcnt = 0;
            if (stray) begin q_ack = 1; q_rts = 4'hF; end
        end
    end

    task automatic run_case(input int d, input int r, input string req);
        int e0;
        ack_delay = d; remote = r;
        e0 = ev;
        for (int i = 0; i < 3 * STAMP_SYS && ev == e0; i++) @(negedge clk);
        check(ev != e0, req, ev, e0 + 1);
    endtask

    task automatic after_stamp();
        int s0;
        s0 = stamp_n;
        for (int i = 0; i < 3 * STAMP_SYS && stamp_n == s0; i++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic quiet_check(input string req);
        int r0;
        r0 = rises;
        after_stamp();
        repeat (2 * STAMP_SYS) @(negedge clk);
        check(rises == r0 && q_req == 0, req, rises, r0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #101;
        ref_rst_n = 1; line_rst_n = 1; rst_n = 1;
        repeat (3) @(negedge clk);
        check(q_req == 0 && syn_vld == 0 && ext_diff == 0, "R9 idle after reset", q_req, 0);

        // R6 R3: several acknowledge delays and remote values, covering signed wrap.
        run_case(0, 3,  "R6 case d0");
        run_case(3, 12, "R6 case d3");
        run_case(7, 0,  "R6 case d7");
        run_case(1, 15, "R6 case d1");
        run_case(2, 8,  "R6 case d2");
        // R8 boundary: acknowledge on the 16th cycle is accepted.
        run_case(15, 9, "R8 ack on last cycle");
        // R8: no acknowledge, and an acknowledge one cycle too late.
        run_case(-1, 0, "R8 timeout no ack");
        run_case(16, 5, "R8 timeout late ack");
        check(ext_diff == 4'(m_ext), "R7 ext held over timeout", ext_diff, m_ext);

        // R1: each gate alone suppresses requests.
        after_stamp(); sw_en = 0;    quiet_check("R1 sw_en low");     sw_en = 1;
        after_stamp(); hw_dis_n = 0; quiet_check("R1 hw_dis_n low");  hw_dis_n = 1;
        after_stamp(); line_udf = 0; quiet_check("R1 line_udf low");  line_udf = 1;
        after_stamp(); line_en = 0;  quiet_check("R1 line_en low");   line_en = 1;

        // R1: gating off during a pending request aborts it.
        ack_delay = -1;
        after_stamp();
        for (int i = 0; i < 3 * STAMP_SYS && !q_req; i++) @(negedge clk);
        check(q_req == 1, "R4 request raised", q_req, 1);
        repeat (3) @(negedge clk);
        sw_en = 0;
        @(negedge clk);
        check(q_req == 0 && syn_vld == 0, "R1 abort drops request", q_req, 0);
        repeat (STAMP_SYS) @(negedge clk);
        sw_en = 1;

        // R5: acknowledge pulses while idle do nothing.
        begin
            int v0;
            after_stamp();
            v0 = vlds;
            stray = 1;
            repeat (10) @(negedge clk);
            stray = 0;
            repeat (3) @(negedge clk);
            check(vlds == v0 && ext_diff == 4'(m_ext), "R5 stray ack ignored", vlds, v0);
        end

        run_case(4, 6, "R6 recovery case");
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule